// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block carries out the bus work a processor core does once it has decided to take an interrupt. A single-cycle accept strobe hands it the source class, the priority level, the current interrupt priority level, the stack pointer, the vector address, the return program counter, the flag bits and the bus-width mode. It then drives a fixed series of zero-wait bus accesses. The series is an acknowledge read, an optional prefetch read, two stack pushes and two vector fetches. At the end it loads the new program counter, stack pointer and priority level.

The time spent is set by three things. The first is the parity of the stack pointer and of the vector address. The second is whether the bus is 16 or 8 bits wide. The third is a fixed surcharge for debug, address-match and single-step sources. A one-cycle done pulse carries the cycle count, so the count can be compared with the expected figure.

Top module: `ient_seq`

## Requirements
- R1: At the end of a sequence, `ipl_out` takes a new value chosen by `src`. For code 0 it takes `level`. For code 1, the watchdog, it takes 7. For codes 2, 3, 4 and 5 it takes `ipl_in`, the value latched at accept.
- R2: Each access asserts `bus_rd` or `bus_wr` for exactly one cycle, and the two are never high together. The order of accesses is fixed:
  - a read at address 0;
  - an optional gap read;
  - a write to SP-2;
  - a write to SP-4;
  - a read at the vector address;
  - a read at vector+2.
- R3: The push to SP-2 carries `{flags_in, pc_in[19:16]}`. The push to SP-4 carries `pc_in[15:0]`.
- R4: After the sequence, `pc_out` is `{rd(vector+2)[3:0], rd(vector)}` and `sp_out` is SP-4. `pc_out` changes only in a done cycle.
- R5: With `bus8`=0, the sequence lasts 18 cycles when SP and the vector are both even. It lasts 19 cycles when exactly one of them is odd, and 20 cycles when both are odd.
- R6: With `bus8`=1, the sequence lasts 20 cycles whatever the parity.
- R7: Source code 3 (debug) adds 2 cycles. Codes 4 (address match) and 5 (single step) add 1 cycle each.
- R8: The gap read is issued only when `queue_ready` is high when the gap begins. It reads address `pc_in`.
- R9: `busy` rises in the cycle after an accepted strobe and stays high for the whole sequence. No bus access occurs while `busy` is low. An accept strobe seen while busy has no effect on the accesses, the timing or the results.
- R10: `done` is high for exactly one cycle, the cycle in which `busy` falls. In that cycle `cycles` equals the number of cycles `busy` was high.
- R11: After reset, `busy`, `done`, `bus_rd`, `bus_wr`, `pc_out`, `sp_out` and `ipl_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | Interrupt accepted strobe |
| src | input | 3 | Source class code |
| level | input | 3 | Priority level of a leveled source |
| ipl_in | input | 3 | Current interrupt priority level |
| sp_in | input | 16 | Stack pointer before entry |
| vec_in | input | 20 | Vector address |
| pc_in | input | 20 | Return program counter |
| flags_in | input | 12 | Flag bits pushed with the high PC bits |
| bus8 | input | 1 | 1 selects the 8-bit bus timing |
| queue_ready | input | 1 | Prefetch queue can take a word |
| bus_rdata | input | 16 | Read data, valid in the strobe cycle |
| bus_addr | output | 20 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cycles | output | 6 | Measured sequence length |
| ipl_out | output | 3 | New interrupt priority level |
| pc_out | output | 20 | New program counter |
| sp_out | output | 16 | New stack pointer |

## Verification
The hardest case to reach is an accept strobe that arrives in the middle of a sequence. Driving it can go wrong in two ways: it can restart the run, or it can corrupt the latched request. The driver raises such a strobe a few cycles into a run and gives it a different source class and level. The scoreboard then requires that the bus trace, the length and the priority level still match the first request, and that no extra access appears. Parity and bus-width corners are covered by sweeping odd and even values of SP and the vector on both widths and with every surcharged source.

// File: rtl/ient_pkg.sv
package ient_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INFO,
    PH_GAP,
    PH_PUSH1,
    PH_PUSH2,
    PH_VLO,
    PH_VHI,
    PH_TAIL
  } ient_phase_e;

  localparam logic [2:0] SRC_LEVEL  = 3'd0;
  localparam logic [2:0] SRC_WDOG   = 3'd1;
  localparam logic [2:0] SRC_PLAIN  = 3'd2;
  localparam logic [2:0] SRC_DEBUG  = 3'd3;
  localparam logic [2:0] SRC_AMATCH = 3'd4;
  localparam logic [2:0] SRC_STEP   = 3'd5;

  localparam logic [2:0] IPL_WDOG   = 3'd7;

endpackage

// File: rtl/ient_timing.sv
module ient_timing
  import ient_pkg::*;
#(
  parameter int DURW     = 4,
  parameter int BASE_DUR = 2,
  parameter int TAIL_DUR = 6
) (
  input  logic [2:0]      src,
  input  logic            bus8,
  input  logic            sp_odd,
  input  logic            vec_odd,
  output logic [DURW-1:0] dur_push1,
  output logic [DURW-1:0] dur_vlo,
  output logic [DURW-1:0] dur_tail
);

  logic [DURW-1:0] extra;

  always_comb begin
    case (src)
      SRC_DEBUG:           extra = DURW'(2);
      SRC_AMATCH, SRC_STEP: extra = DURW'(1);
      default:             extra = '0;
    endcase
  end

  // A narrow bus always pays the misaligned penalty on both the stack and vector side.
  assign dur_push1 = DURW'(BASE_DUR) + DURW'(bus8 | sp_odd);
  assign dur_vlo   = DURW'(BASE_DUR) + DURW'(bus8 | vec_odd);
  assign dur_tail  = DURW'(TAIL_DUR) + extra;

endmodule

// File: rtl/ient_ctrl.sv
module ient_ctrl
  import ient_pkg::*;
#(
  parameter int DURW     = 4,
  parameter int CW       = 6,
  parameter int BASE_DUR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [DURW-1:0] dur_push1,
  input  logic [DURW-1:0] dur_vlo,
  input  logic [DURW-1:0] dur_tail,
  output ient_phase_e     phase_q,
  output ient_phase_e     phase_d,
  output logic            enter,
  output logic            first,
  output logic            fin,
  output logic [CW-1:0]   elapsed
);

  logic [DURW-1:0] cnt_q;
  logic [DURW-1:0] dur_cur;
  logic            last;
  ient_phase_e     nxt;

  always_comb begin
    case (phase_q)
      PH_PUSH1: dur_cur = dur_push1;
      PH_VLO:   dur_cur = dur_vlo;
      PH_TAIL:  dur_cur = dur_tail;
      default:  dur_cur = DURW'(BASE_DUR);
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_INFO:  nxt = PH_GAP;
      PH_GAP:   nxt = PH_PUSH1;
      PH_PUSH1: nxt = PH_PUSH2;
      PH_PUSH2: nxt = PH_VLO;
      PH_VLO:   nxt = PH_VHI;
      PH_VHI:   nxt = PH_TAIL;
      default:  nxt = PH_IDLE;
    endcase
  end

  assign last  = (cnt_q == dur_cur - DURW'(1));
  assign first = (cnt_q == '0);
  assign fin   = (phase_q == PH_TAIL) && last;

  always_comb begin
    phase_d = phase_q;
    if (start)
      phase_d = PH_INFO;
    else if (phase_q != PH_IDLE && last)
      phase_d = nxt;
  end

  assign enter = (phase_d != phase_q) && (phase_d != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      elapsed <= '0;
    end else begin
      phase_q <= phase_d;
      if (start) begin
        cnt_q   <= '0;
        elapsed <= '0;
      end else if (phase_q != PH_IDLE) begin
        elapsed <= elapsed + CW'(1);
        cnt_q   <= last ? '0 : cnt_q + DURW'(1);
      end
    end
  end

endmodule

// File: rtl/ient_datapath.sv
module ient_datapath
  import ient_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int SPW = 16,
  parameter int CW  = 6,
  parameter int PCH = AW - DW,
  parameter int FLW = DW - PCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  ient_phase_e     phase_q,
  input  ient_phase_e     phase_d,
  input  logic            enter,
  input  logic            first,
  input  logic            fin,
  input  logic [CW-1:0]   elapsed,
  input  logic [2:0]      src,
  input  logic [2:0]      level,
  input  logic [2:0]      ipl_in,
  input  logic [SPW-1:0]  sp_in,
  input  logic [AW-1:0]   vec_in,
  input  logic [AW-1:0]   pc_in,
  input  logic [FLW-1:0]  flags_in,
  input  logic            bus8,
  input  logic            queue_ready,
  input  logic [DW-1:0]   bus_rdata,
  output logic [2:0]      src_l,
  output logic            bus8_l,
  output logic            sp_odd,
  output logic            vec_odd,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            done,
  output logic [CW-1:0]   cycles,
  output logic [2:0]      ipl_out,
  output logic [AW-1:0]   pc_out,
  output logic [SPW-1:0]  sp_out
);

  logic [2:0]     lvl_l;
  logic [2:0]     ipl_l;
  logic [SPW-1:0] sp_l;
  logic [AW-1:0]  vec_l;
  logic [AW-1:0]  pc_l;
  logic [FLW-1:0] flg_l;
  logic [DW-1:0]  lo_q;
  logic [PCH-1:0] hi_q;
  logic [SPW-1:0] sp_m2;
  logic [SPW-1:0] sp_m4;
  logic [2:0]     ipl_new;
  logic           unused_hi;

  assign sp_m2     = sp_l - SPW'(2);
  assign sp_m4     = sp_l - SPW'(4);
  assign sp_odd    = sp_l[0];
  assign vec_odd   = vec_l[0];
  assign unused_hi = &{1'b0, bus_rdata[DW-1:PCH]};

  always_comb begin
    case (src_l)
      SRC_LEVEL: ipl_new = lvl_l;
      SRC_WDOG:  ipl_new = IPL_WDOG;
      default:   ipl_new = ipl_l;
    endcase
  end

  // Request latch: captured once per accepted strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_l  <= '0;
      lvl_l  <= '0;
      ipl_l  <= '0;
      sp_l   <= '0;
      vec_l  <= '0;
      pc_l   <= '0;
      flg_l  <= '0;
      bus8_l <= 1'b0;
    end else if (start) begin
      src_l  <= src;
      lvl_l  <= level;
      ipl_l  <= ipl_in;
      sp_l   <= sp_in;
      vec_l  <= vec_in;
      pc_l   <= pc_in;
      flg_l  <= flags_in;
      bus8_l <= bus8;
    end
  end

  // Bus drive: one strobe cycle at the start of each phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
    end else begin
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
      if (enter) begin
        case (phase_d)
          PH_INFO: begin
            bus_rd   <= 1'b1;
            bus_addr <= '0;
          end
          PH_GAP: begin
            bus_rd   <= queue_ready;
            bus_addr <= pc_l;
          end
          PH_PUSH1: begin
            bus_wr    <= 1'b1;
            bus_addr  <= AW'(sp_m2);
            bus_wdata <= {flg_l, pc_l[AW-1:DW]};
          end
          PH_PUSH2: begin
            bus_wr    <= 1'b1;
            bus_addr  <= AW'(sp_m4);
            bus_wdata <= pc_l[DW-1:0];
          end
          PH_VLO: begin
            bus_rd   <= 1'b1;
            bus_addr <= vec_l;
          end
          PH_VHI: begin
            bus_rd   <= 1'b1;
            bus_addr <= vec_l + AW'(2);
          end
          default: ;
        endcase
      end
    end
  end

  // Vector capture and result registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      done    <= 1'b0;
      cycles  <= '0;
      ipl_out <= '0;
      pc_out  <= '0;
      sp_out  <= '0;
    end else begin
      if (phase_q == PH_VLO && first)
        lo_q <= bus_rdata;
      if (phase_q == PH_VHI && first)
        hi_q <= bus_rdata[PCH-1:0];
      done <= fin;
      if (fin) begin
        cycles  <= elapsed + CW'(1);
        ipl_out <= ipl_new;
        pc_out  <= {hi_q, lo_q};
        sp_out  <= sp_m4;
      end
    end
  end

endmodule

// File: rtl/ient_seq.sv
module ient_seq
  import ient_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int SPW      = 16,
  parameter int CW       = 6,
  parameter int DURW     = 4,
  parameter int BASE_DUR = 2,
  parameter int TAIL_DUR = 6,
  parameter int FLW      = DW - (AW - DW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [2:0]      src,
  input  logic [2:0]      level,
  input  logic [2:0]      ipl_in,
  input  logic [SPW-1:0]  sp_in,
  input  logic [AW-1:0]   vec_in,
  input  logic [AW-1:0]   pc_in,
  input  logic [FLW-1:0]  flags_in,
  input  logic            bus8,
  input  logic            queue_ready,
  input  logic [DW-1:0]   bus_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   cycles,
  output logic [2:0]      ipl_out,
  output logic [AW-1:0]   pc_out,
  output logic [SPW-1:0]  sp_out
);

  ient_phase_e     phase_q;
  ient_phase_e     phase_d;
  logic            enter;
  logic            first;
  logic            fin;
  logic            start;
  logic [CW-1:0]   elapsed;
  logic [2:0]      src_l;
  logic            bus8_l;
  logic            sp_odd;
  logic            vec_odd;
  logic [DURW-1:0] dur_push1;
  logic [DURW-1:0] dur_vlo;
  logic [DURW-1:0] dur_tail;

  assign busy  = (phase_q != PH_IDLE);
  assign start = accept && !busy;

  ient_timing #(
    .DURW(DURW), .BASE_DUR(BASE_DUR), .TAIL_DUR(TAIL_DUR)
  ) u_timing (
    .src(src_l), .bus8(bus8_l), .sp_odd(sp_odd), .vec_odd(vec_odd),
    .dur_push1(dur_push1), .dur_vlo(dur_vlo), .dur_tail(dur_tail)
  );

  ient_ctrl #(
    .DURW(DURW), .CW(CW), .BASE_DUR(BASE_DUR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dur_push1(dur_push1), .dur_vlo(dur_vlo), .dur_tail(dur_tail),
    .phase_q(phase_q), .phase_d(phase_d), .enter(enter),
    .first(first), .fin(fin), .elapsed(elapsed)
  );

  ient_datapath #(
    .AW(AW), .DW(DW), .SPW(SPW), .CW(CW)
  ) u_dp (
    .clk(clk), .rst(rst), .start(start),
    .phase_q(phase_q), .phase_d(phase_d), .enter(enter),
    .first(first), .fin(fin), .elapsed(elapsed),
    .src(src), .level(level), .ipl_in(ipl_in), .sp_in(sp_in),
    .vec_in(vec_in), .pc_in(pc_in), .flags_in(flags_in), .bus8(bus8),
    .queue_ready(queue_ready), .bus_rdata(bus_rdata),
    .src_l(src_l), .bus8_l(bus8_l), .sp_odd(sp_odd), .vec_odd(vec_odd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .done(done), .cycles(cycles), .ipl_out(ipl_out),
    .pc_out(pc_out), .sp_out(sp_out)
  );

endmodule

// File: rtl/ient_seq_chk.sv
module ient_seq_chk #(
  parameter int AW      = 20,
  parameter int CW      = 6,
  parameter int MIN_LEN = 18,
  parameter int MAX_LEN = 22
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] pc_out,
  input logic [CW-1:0] cycles
);

  logic [CW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else     len_q <= busy ? len_q + CW'(1) : '0;
  end

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_rd && !bus_wr));

  // R10
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  len_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles == len_q));

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pc_out));

  // R7
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles >= CW'(MIN_LEN) && cycles <= CW'(MAX_LEN)));

endmodule

bind ient_seq ient_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .pc_out(pc_out), .cycles(cycles)
);

// File: tb/test_ient_seq.sv
module test_ient_seq;

  typedef struct {
    logic        rd;
    logic [19:0] addr;
    logic [15:0] data;
  } bus_t;

  typedef struct {
    int          len;
    logic [19:0] pc;
    logic [2:0]  ipl;
    logic [15:0] sp;
  } res_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accept = 1'b0;
  logic [2:0]  src = '0, level = '0, ipl_in = '0;
  logic [15:0] sp_in = '0;
  logic [19:0] vec_in = '0, pc_in = '0;
  logic [11:0] flags_in = '0;
  logic        bus8 = 1'b0, queue_ready = 1'b0;
  logic [15:0] bus_rdata;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_rd, bus_wr, busy, done;
  logic [5:0]  cycles;
  logic [2:0]  ipl_out;
  logic [19:0] pc_out;
  logic [15:0] sp_out;

  int checks = 0;
  int errors = 0;
  int blen   = 0;
  int wdog   = 0;
  bus_t exp_bus[$];
  res_t exp_res[$];

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [19:0] a);
    return a[15:0] ^ 16'h3C96 ^ {a[19:16], 12'h0};
  endfunction

  assign bus_rdata = mem_f(bus_addr);

  ient_seq i_ient_seq (
    .clk(clk), .rst(rst), .accept(accept), .src(src), .level(level),
    .ipl_in(ipl_in), .sp_in(sp_in), .vec_in(vec_in), .pc_in(pc_in),
    .flags_in(flags_in), .bus8(bus8), .queue_ready(queue_ready),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .busy(busy), .done(done),
    .cycles(cycles), .ipl_out(ipl_out), .pc_out(pc_out), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops scoreboard items as the design produces them.
  always @(negedge clk) begin
    if (!rst) begin
      wdog++;
      if (wdog > 100000) begin
        chk(1'b0, "watchdog", wdog, 0);
        finish_run();
      end
      if (bus_rd || bus_wr) begin
        if (exp_bus.size() == 0) begin
          chk(1'b0, "R9 unexpected access", bus_addr, 0);
        end else begin
          bus_t e;
          e = exp_bus.pop_front();
          chk(bus_rd == e.rd && bus_wr == !e.rd, "R2 strobe kind", {bus_rd, bus_wr}, {e.rd, !e.rd});
          chk(bus_addr == e.addr, "R2 access address", bus_addr, e.addr);
          if (!e.rd) chk(bus_wdata == e.data, "R3 push data", bus_wdata, e.data);
        end
      end
      if (busy) blen++;
      if (done) begin
        if (exp_res.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          res_t r;
          r = exp_res.pop_front();
          chk(blen == r.len, "R5 R6 R7 busy length", blen, r.len);
          chk(cycles == r.len, "R10 cycles output", cycles, r.len);
          chk(pc_out == r.pc, "R4 new pc", pc_out, r.pc);
          chk(sp_out == r.sp, "R4 new sp", sp_out, r.sp);
          chk(ipl_out == r.ipl, "R1 new ipl", ipl_out, r.ipl);
          chk(!busy, "R10 busy low at done", busy, 0);
        end
        blen = 0;
      end
    end
  end

  // Driver: predicts the trace, then issues the accept strobe.
  task automatic run_int(input logic [2:0] s, input logic [2:0] lv, input logic [2:0] ipi,
                         input logic [15:0] sp, input logic [19:0] vec, input logic [19:0] pc,
                         input logic [11:0] fl, input logic b8, input logic qr, input bit poke);
    bus_t b;
    res_t r;
    int   len;
    len = 18 + (b8 ? 2 : (int'(sp[0]) + int'(vec[0])));
    if (s == 3'd3) len += 2;
    if (s == 3'd4 || s == 3'd5) len += 1;
    b = '{1'b1, 20'h0, 16'h0};                      exp_bus.push_back(b);
    if (qr) begin b = '{1'b1, pc, 16'h0};           exp_bus.push_back(b); end
    b = '{1'b0, {4'h0, sp - 16'd2}, {fl, pc[19:16]}}; exp_bus.push_back(b);
    b = '{1'b0, {4'h0, sp - 16'd4}, pc[15:0]};      exp_bus.push_back(b);
    b = '{1'b1, vec, 16'h0};                        exp_bus.push_back(b);
    b = '{1'b1, vec + 20'd2, 16'h0};                exp_bus.push_back(b);
    r.len = len;
    r.pc  = {mem_f(vec + 20'd2)[3:0], mem_f(vec)};
    r.sp  = sp - 16'd4;
    r.ipl = (s == 3'd0) ? lv : (s == 3'd1) ? 3'd7 : ipi;
    exp_res.push_back(r);

    @(negedge clk);
    src = s; level = lv; ipl_in = ipi; sp_in = sp; vec_in = vec; pc_in = pc;
    flags_in = fl; bus8 = b8; queue_ready = qr; accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      src = 3'd1; level = 3'd2; ipl_in = 3'd6; sp_in = 16'h0101; vec_in = 20'h0F0F1;
      accept = 1'b1;  // R9: ignored while busy
      @(negedge clk);
      accept = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_bus.size() == 0, "R2 R8 R9 all accesses seen", exp_bus.size(), 0);
    exp_bus.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk(!busy && !done, "R11 busy/done after reset", {busy, done}, 0);
    chk(!bus_rd && !bus_wr, "R11 strobes after reset", {bus_rd, bus_wr}, 0);
    chk(pc_out == 0 && sp_out == 0 && ipl_out == 0, "R11 results after reset",
        {pc_out, sp_out, ipl_out}, 0);

    // src codes: 0 leveled, 1 watchdog, 2 plain, 3 debug, 4 address match, 5 step
    run_int(3'd0, 3'd5, 3'd1, 16'h1000, 20'hFFF00, 20'h5A3C7, 12'hABC, 1'b0, 1'b0, 1'b0); // R5 even/even, R1
    run_int(3'd1, 3'd2, 3'd3, 16'h2001, 20'hFFF04, 20'h12345, 12'h123, 1'b0, 1'b0, 1'b0); // R5 sp odd, R1 wdog
    run_int(3'd2, 3'd6, 3'd3, 16'h3000, 20'hFFF09, 20'hABCDE, 12'hF0F, 1'b0, 1'b1, 1'b0); // R5 vec odd, R8
    run_int(3'd0, 3'd1, 3'd0, 16'h4003, 20'hFFF11, 20'h0FFFF, 12'h555, 1'b0, 1'b0, 1'b0); // R5 both odd
    run_int(3'd0, 3'd4, 3'd2, 16'h5000, 20'hFFF20, 20'h7777A, 12'h0AA, 1'b1, 1'b1, 1'b0); // R6 even
    run_int(3'd2, 3'd4, 3'd5, 16'h6007, 20'hFFF2B, 20'h80001, 12'hFFF, 1'b1, 1'b0, 1'b0); // R6 odd
    run_int(3'd3, 3'd7, 3'd4, 16'h7000, 20'hFFF30, 20'h00100, 12'h001, 1'b0, 1'b0, 1'b0); // R7 debug
    run_int(3'd4, 3'd7, 3'd6, 16'h8005, 20'hFFF34, 20'h44444, 12'h800, 1'b0, 1'b1, 1'b0); // R7 address match
    run_int(3'd5, 3'd3, 3'd2, 16'h9000, 20'hFFF38, 20'hEDCBA, 12'h777, 1'b1, 1'b0, 1'b0); // R7 step, 8-bit
    run_int(3'd0, 3'd3, 3'd0, 16'hA002, 20'hFFF40, 20'h31415, 12'h926, 1'b0, 1'b0, 1'b1); // R9 ignored accept
    run_int(3'd3, 3'd0, 3'd7, 16'h0003, 20'hFFF45, 20'h27182, 12'h818, 1'b1, 1'b1, 1'b1); // R9 R7 R6
    chk(exp_res.size() == 0, "R10 all results seen", exp_res.size(), 0);
    finish_run();
  end

endmodule